// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave side of a serial EEPROM. It connects to an SPI master through chip select, serial clock, serial data in, an active-low hold input, and a serial data output with its own drive enable. All of these are brought into the core clock domain, which oversamples them. The block decodes a one-byte opcode, gathers a 16-bit big-endian address, and carries out the command. Memory writes collect data bytes into a page buffer. When chip select is released, the buffer is committed in a self-timed write cycle whose length is a parameter in core clock cycles. Memory reads stream bytes out and increment the address after each one.

The nonvolatile array is modelled as byte registers and is split into 32-byte pages. With `ARRAY_AW = 13` it holds 8192 bytes. The default is a smaller size so that default elaboration stays light. The companion status block supplies the upper six status bits. It receives a one-cycle write request carrying the byte sent by a status-write command. The block owns the write-enable latch and the busy flag.

Opcodes are 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read, and 0x02 write. Address bits above `ARRAY_AW` are ignored.

Top module: `eep_cmd_engine`

## Requirements
- R1: Input bits are taken on rising serial-clock edges and output bits change after falling edges, MSB first. Both idle levels of the clock (mode 0 and mode 3) work.
- R2: A frame of exactly one opcode byte ending at deselect sets the write-enable latch (0x06) or clears it (0x04). Read status (0x05) returns repeatedly the byte {stat_hi_i[5:0], latch in bit 1, busy in bit 0}.
- R3: A write (0x02) is committed only if chip select rises after at least one data byte, with no bits beyond a byte boundary. Otherwise nothing is written and no write cycle starts.
- R4: Write (0x02) and status write (0x01) are ignored when the write-enable latch is clear.
- R5: A read (0x03) starts at any byte and increments the address after every byte while selected. It wraps from the top of the array to address 0. Address bits at and above ARRAY_AW are ignored.
- R6: Page-write data wraps inside its 32-byte page. When more than 32 bytes are sent, later bytes overwrite earlier ones at the same column.
- R7: A committed write keeps busy set for WR_CYCLES core cycles. While busy, every opcode except read status is ignored, and a read never drives the output.
- R8: The write-enable latch clears at the end of a write cycle, on a clear-enable command, and on an accepted status write.
- R9: While selected with hold_ni low, clock and data input are ignored and the output is not driven. The frame resumes when hold is released.
- R10: After reset, no frame starts until chip select has first been seen high.
- R11: A status write with exactly one data byte, ending on a byte boundary, raises stat_we_o for one cycle with that byte on stat_wdata_o. Any other length gives no request.
- R12: After reset the output is not driven, the latch and busy are clear, and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| stat_hi_i | input | 6 | Upper status bits from the companion block |
| stat_we_o | output | 1 | One-cycle status write request |
| stat_wdata_o | output | 8 | Status byte carried by the request |

## Verification
The bench builds the block with a 512-byte array (`ARRAY_AW = 9`) and a 2000-cycle write time. The small array lets one short read cross the top-of-array wrap, and it gives a 16-bit address whose upper bits must be discarded. The short write time lets a single test issue a read, an enable and a second write while the cycle is still busy, and still keeps many full write cycles within the run.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [3:0] {
    ST_OP, ST_CMD1, ST_AH, ST_AL, ST_WDAT, ST_RDAT, ST_SRR, ST_SRW, ST_SRDONE, ST_SKIP
  } st_e;
endpackage

// File: rtl/eep_spi_front.sv
module eep_spi_front (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  input  logic       hold_ni,
  input  logic       tx_load_i,
  input  logic [7:0] tx_byte_i,
  input  logic       tx_en_i,
  output logic       sel_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       bit_zero_o,
  output logic       frame_end_o,
  output logic       sdo_o,
  output logic       sdo_oe_o
);
  logic [1:0] cs_sy, sck_sy, sdi_sy, hold_sy;
  logic       cs_q, sck_q, armed_q, oe_q, sdo_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_q;
  logic [7:0] tx_q;
  logic       held, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sy   <= 2'b00;
      sck_sy  <= 2'b00;
      sdi_sy  <= 2'b00;
      hold_sy <= 2'b11;
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cs_sy   <= {cs_sy[0], cs_ni};
      sck_sy  <= {sck_sy[0], sck_i};
      sdi_sy  <= {sdi_sy[0], sdi_i};
      hold_sy <= {hold_sy[0], hold_ni};
      cs_q    <= cs_sy[1];
      sck_q   <= sck_sy[1];
      if (cs_sy[1]) armed_q <= 1'b1;  // a frame needs a prior deselect
    end
  end

  assign sel_o       = armed_q & ~cs_sy[1];
  assign held        = sel_o & ~hold_sy[1];
  assign rise        = sel_o & ~held & sck_sy[1] & ~sck_q;
  assign fall        = sel_o & ~held & ~sck_sy[1] & sck_q;
  assign frame_end_o = armed_q & cs_sy[1] & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      oe_q      <= 1'b0;
    end else if (!sel_o) begin
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      if (rise) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
        rx_q      <= {rx_q[5:0], sdi_sy[1]};
      end
      if (fall) oe_q <= tx_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      sdo_q <= 1'b0;
    end else if (tx_load_i) begin
      tx_q <= tx_byte_i;
    end else if (fall) begin
      sdo_q <= tx_q[7];
      tx_q  <= {tx_q[6:0], 1'b0};
    end
  end

  assign rx_byte_o   = {rx_q, sdi_sy[1]};
  assign byte_done_o = rise & (bit_cnt_q == 3'd7);
  assign bit_zero_o  = (bit_cnt_q == 3'd0);
  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = oe_q & ~held;

  a_r9_hold_freezes_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |=> (bit_cnt_q == $past(bit_cnt_q)));
  a_r10_quiet_until_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (bit_cnt_q == 3'd0) && !oe_q);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_AW = 5,
  localparam int NL     = 1 << PAGE_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [PAGE_AW-1:0] col_i,
  input  logic [7:0]         d_i,
  output logic [NL-1:0]      mask_o,
  output logic [8*NL-1:0]    data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      data_o <= '0;
    end else if (clr_i) begin
      mask_o <= '0;
    end else if (we_i) begin
      mask_o[col_i]         <= 1'b1;
      data_o[8*col_i +: 8]  <= d_i;  // later byte to same column wins
    end
  end

  a_r6_lane_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mask_o[$past(col_i)]);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ARRAY_AW  = 11,
  parameter int PAGE_AW   = 5,
  parameter int WR_CYCLES = 500000,
  localparam int DEPTH    = 1 << ARRAY_AW,
  localparam int NL       = 1 << PAGE_AW,
  localparam int CW       = $clog2(WR_CYCLES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ARRAY_AW-1:0]         raddr_i,
  output logic [7:0]                  rdata_o,
  input  logic                        start_i,
  input  logic [ARRAY_AW-PAGE_AW-1:0] page_i,
  input  logic [NL-1:0]               mask_i,
  input  logic [8*NL-1:0]             data_i,
  output logic                        busy_o,
  output logic                        done_o
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= CW'(WR_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o & (cnt_q == '0);

  // cells take the buffered bytes at the end of the timed cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done_o) begin
      for (int l = 0; l < NL; l++)
        if (mask_i[l]) mem[{page_i, PAGE_AW'(l)}] <= data_i[8*l +: 8];
    end
  end

  assign rdata_o = mem[raddr_i];

  a_r7_no_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine
  import eep_pkg::*;
#(
  parameter int ARRAY_AW  = 11,
  parameter int PAGE_AW   = 5,
  parameter int WR_CYCLES = 500000,
  localparam int NL       = 1 << PAGE_AW,
  localparam int PGW      = ARRAY_AW - PAGE_AW
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  input  logic       hold_ni,
  output logic       sdo_o,
  output logic       sdo_oe_o,
  input  logic [5:0] stat_hi_i,
  output logic       stat_we_o,
  output logic [7:0] stat_wdata_o
);
  st_e                 st_q;
  logic                sel, byte_done, bit_zero, frame_end;
  logic [7:0]          rx_byte, tx_byte, rdata, status;
  logic                tx_load, tx_en;
  logic                is_wr_q, pend_set_q, wel_q;
  logic [ARRAY_AW-9:0] ahi_q;
  logic [ARRAY_AW-1:0] a_full, rd_addr_q, raddr;
  logic [PAGE_AW-1:0]  col_q;
  logic [PGW-1:0]      page_q;
  logic [7:0]          sr_q;
  logic [NL-1:0]       mask;
  logic [8*NL-1:0]     bdata;
  logic                busy, arr_done, end_ok, arr_start, sr_commit, wren_c, wrdi_c;

  eep_spi_front u_front (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .sdi_i, .hold_ni,
    .tx_load_i(tx_load), .tx_byte_i(tx_byte), .tx_en_i(tx_en),
    .sel_o(sel), .byte_done_o(byte_done), .rx_byte_o(rx_byte),
    .bit_zero_o(bit_zero), .frame_end_o(frame_end),
    .sdo_o, .sdo_oe_o
  );

  assign a_full = {ahi_q, rx_byte};
  assign status = {stat_hi_i, wel_q, busy};

  assign tx_load = byte_done & (((st_q == ST_OP) & (rx_byte == OP_RDSR)) | (st_q == ST_SRR) |
                                ((st_q == ST_AL) & ~is_wr_q) | (st_q == ST_RDAT));
  assign tx_byte = ((st_q == ST_OP) | (st_q == ST_SRR)) ? status : rdata;
  assign tx_en   = (st_q == ST_RDAT) | (st_q == ST_SRR);
  assign raddr   = (st_q == ST_AL) ? a_full : rd_addr_q + 1'b1;

  assign end_ok    = frame_end & bit_zero;
  assign arr_start = end_ok & (st_q == ST_WDAT) & (|mask);
  assign sr_commit = end_ok & (st_q == ST_SRDONE);
  assign wren_c    = end_ok & (st_q == ST_CMD1) & pend_set_q;
  assign wrdi_c    = end_ok & (st_q == ST_CMD1) & ~pend_set_q;

  eep_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
    .clk_i, .rst_ni,
    .clr_i(byte_done & (st_q == ST_AL) & is_wr_q),
    .we_i(byte_done & (st_q == ST_WDAT)),
    .col_i(col_q), .d_i(rx_byte),
    .mask_o(mask), .data_o(bdata)
  );

  eep_array #(.ARRAY_AW(ARRAY_AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_array (
    .clk_i, .rst_ni,
    .raddr_i(raddr), .rdata_o(rdata),
    .start_i(arr_start), .page_i(page_q), .mask_i(mask), .data_i(bdata),
    .busy_o(busy), .done_o(arr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_OP;
      is_wr_q    <= 1'b0;
      pend_set_q <= 1'b0;
      ahi_q      <= '0;
      col_q      <= '0;
      page_q     <= '0;
      rd_addr_q  <= '0;
      sr_q       <= '0;
    end else if (!sel) begin
      st_q <= ST_OP;
    end else if (byte_done) begin
      unique case (st_q)
        ST_OP: begin
          if (rx_byte == OP_WREN || rx_byte == OP_WRDI) begin
            st_q       <= busy ? ST_SKIP : ST_CMD1;
            pend_set_q <= (rx_byte == OP_WREN);
          end else if (rx_byte == OP_RDSR) begin
            st_q <= ST_SRR;
          end else if (rx_byte == OP_WRSR) begin
            st_q <= (busy || !wel_q) ? ST_SKIP : ST_SRW;
          end else if (rx_byte == OP_READ) begin
            st_q    <= busy ? ST_SKIP : ST_AH;
            is_wr_q <= 1'b0;
          end else if (rx_byte == OP_WRITE) begin
            st_q    <= (busy || !wel_q) ? ST_SKIP : ST_AH;
            is_wr_q <= 1'b1;
          end else begin
            st_q <= ST_SKIP;
          end
        end
        ST_AH: begin
          ahi_q <= rx_byte[ARRAY_AW-9:0];
          st_q  <= ST_AL;
        end
        ST_AL: begin
          if (is_wr_q) begin
            col_q  <= a_full[PAGE_AW-1:0];
            page_q <= a_full[ARRAY_AW-1:PAGE_AW];
            st_q   <= ST_WDAT;
          end else begin
            rd_addr_q <= a_full;
            st_q      <= ST_RDAT;
          end
        end
        ST_WDAT:   col_q <= col_q + 1'b1;  // wraps inside the page
        ST_RDAT:   rd_addr_q <= rd_addr_q + 1'b1;
        ST_SRR:    st_q <= ST_SRR;
        ST_SRW: begin
          sr_q <= rx_byte;
          st_q <= ST_SRDONE;
        end
        default:   st_q <= ST_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q     <= 1'b0;
      stat_we_o <= 1'b0;
    end else begin
      stat_we_o <= sr_commit;
      if (wren_c) wel_q <= 1'b1;
      else if (wrdi_c || sr_commit || arr_done) wel_q <= 1'b0;
    end
  end

  assign stat_wdata_o = sr_q;

  a_r4_write_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel_q));
  a_r8_wel_clear_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_done |=> !wel_q);
  a_r7_read_rejected_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && sel && st_q == ST_OP && rx_byte == OP_READ && busy) |=> st_q == ST_SKIP);
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_o |=> !stat_we_o);
endmodule

// File: tb/sim_eep_cmd_engine.sv
`timescale 1ns/1ps
module sim_eep_cmd_engine;
  localparam int AW = 9, WRC = 2000, H = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic [5:0] stat_hi = 6'b101101;
  logic sdo, sdo_oe, stat_we;
  logic [7:0] stat_wd;
  int n_chk = 0, n_bad = 0, we_cnt = 0, oe_cnt = 0;
  logic [7:0] we_last = 8'h00;
  bit mode3 = 1'b0;
  logic [7:0] wb [40];
  logic [7:0] rb [8];

  always #2.5 clk = ~clk;

  eep_cmd_engine #(.ARRAY_AW(AW), .PAGE_AW(5), .WR_CYCLES(WRC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi), .hold_ni(hold_n),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .stat_hi_i(stat_hi),
    .stat_we_o(stat_we), .stat_wdata_o(stat_wd)
  );

  always @(posedge clk) begin
    if (stat_we) begin we_cnt++; we_last = stat_wd; end
    if (sdo_oe) oe_cnt++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_f();
    sck = mode3; tk(2); cs_n = 1'b0; tk(H);
  endtask

  task automatic end_f();
    tk(H); cs_n = 1'b1; tk(4*H);
  endtask

  task automatic xbit(input logic b, output logic r);
    if (mode3) begin
      sck = 1'b0; tk(H); sdi = b; tk(2); r = sdo; sck = 1'b1; tk(H);
    end else begin
      sdi = b; tk(H); r = sdo; sck = 1'b1; tk(H); sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    begin_f(); xbyte(op, d); end_f();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    begin_f(); xbyte(8'h05, d); xbyte(8'h00, s); end_f();
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    logic [7:0] d;
    begin_f(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(wb[i], d);
    end_f();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] d;
    begin_f(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(8'h00, rb[i]);
    end_f();
  endtask

  task automatic wait_wc();
    tk(WRC + 60);
  endtask

  task automatic t_reset();
    logic [7:0] s, d;
    tk(5); rst_n = 1'b1; tk(4);
    chk("R12 oe after reset", sdo_oe, 1'b0);
    // frame with cs low since reset must be ignored
    xbyte(8'h06, d); tk(H); cs_n = 1'b1; tk(4*H);
    rdsr(s);
    chk("R10 enable ignored before first deselect", s, {stat_hi, 2'b00});
    rd(16'h0005, 1);
    chk("R12 erased byte", rb[0], 8'hFF);
  endtask

  task automatic t_wel();
    logic [7:0] s;
    cmd1(8'h06); rdsr(s);
    chk("R2 status after enable", s, {stat_hi, 2'b10});
    cmd1(8'h04); rdsr(s);
    chk("R8 status after disable", s, {stat_hi, 2'b00});
  endtask

  task automatic t_basic();
    logic [7:0] s;
    cmd1(8'h06);
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
    wr(16'h0023, 4);
    rdsr(s);
    chk("R7 busy during cycle", s, {stat_hi, 2'b11});
    wait_wc(); rdsr(s);
    chk("R8 latch clear after cycle", s, {stat_hi, 2'b00});
    rd(16'h0023, 4);
    for (int i = 0; i < 4; i++) chk("R3 R1 mode0 readback", rb[i], wb[i]);
  endtask

  task automatic t_mode3();
    logic [7:0] s;
    mode3 = 1'b1;
    rd(16'h0024, 3);
    chk("R1 mode3 read b0", rb[0], 8'h22);
    chk("R1 mode3 read b2", rb[2], 8'h44);
    rdsr(s);
    chk("R1 mode3 status", s, {stat_hi, 2'b00});
    mode3 = 1'b0;
  endtask

  task automatic t_partial();
    logic [7:0] s, d;
    logic r;
    cmd1(8'h06);
    begin_f(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h50, d); xbyte(8'h5A, d);
    xbit(1'b1, r); xbit(1'b0, r); xbit(1'b1, r); end_f();
    rdsr(s);
    chk("R3 unaligned end starts no cycle", s, {stat_hi, 2'b10});
    begin_f(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h51, d); end_f();
    rdsr(s);
    chk("R3 no data byte starts no cycle", s, {stat_hi, 2'b10});
    rd(16'h0050, 2);
    chk("R3 unaligned data discarded", rb[0], 8'hFF);
    chk("R3 address-only frame writes nothing", rb[1], 8'hFF);
  endtask

  task automatic t_no_wel();
    logic [7:0] s, d;
    int w0;
    cmd1(8'h04);
    wb[0] = 8'h77; wr(16'h0060, 1);
    rdsr(s);
    chk("R4 write without latch idle", s, {stat_hi, 2'b00});
    rd(16'h0060, 1);
    chk("R4 write without latch data", rb[0], 8'hFF);
    w0 = we_cnt;
    begin_f(); xbyte(8'h01, d); xbyte(8'h3C, d); end_f();
    chk("R4 status write without latch", we_cnt - w0, 0);
  endtask

  task automatic t_wrap();
    cmd1(8'h06);
    wb[0] = 8'hA1; wb[1] = 8'hA2; wb[2] = 8'hA3; wb[3] = 8'hA4;
    wr(16'h005E, 4); wait_wc();
    rd(16'h005E, 2);
    chk("R6 tail of page", rb[0], 8'hA1);
    chk("R6 last column", rb[1], 8'hA2);
    rd(16'h0040, 2);
    chk("R6 wrapped to page start", rb[0], 8'hA3);
    chk("R6 wrapped second", rb[1], 8'hA4);
    cmd1(8'h06);
    for (int i = 0; i < 33; i++) wb[i] = 8'h80 + 8'(i);
    wr(16'h0060, 33); wait_wc();
    rd(16'h0060, 2);
    chk("R6 overwrite by 33rd byte", rb[0], 8'hA0);
    chk("R6 second column kept", rb[1], 8'h81);
  endtask

  task automatic t_rdwrap();
    cmd1(8'h06); wb[0] = 8'hC1; wb[1] = 8'hC2; wr(16'h01FE, 2); wait_wc();
    cmd1(8'h06); wb[0] = 8'hD1; wb[1] = 8'hD2; wr(16'h0000, 2); wait_wc();
    rd(16'hE1FE, 4);
    chk("R5 start with upper bits set", rb[0], 8'hC1);
    chk("R5 increment", rb[1], 8'hC2);
    chk("R5 wrap to zero", rb[2], 8'hD1);
    chk("R5 after wrap", rb[3], 8'hD2);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    int o0;
    cmd1(8'h06); wb[0] = 8'h5C; wr(16'h0100, 1);
    o0 = oe_cnt;
    rd(16'h0100, 1);
    chk("R7 read during cycle not driven", oe_cnt - o0, 0);
    cmd1(8'h06); wb[0] = 8'hEE; wr(16'h0100, 1);
    wait_wc(); rdsr(s);
    chk("R7 enable during cycle ignored", s, {stat_hi, 2'b00});
    rd(16'h0100, 1);
    chk("R7 write during cycle ignored", rb[0], 8'h5C);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    cmd1(8'h06);
    begin_f(); xbyte(8'h02, d); xbyte(8'h01, d); xbyte(8'h20, d); xbyte(8'h3D, d);
    hold_n = 1'b0; tk(H);
    for (int i = 0; i < 8; i++) begin
      sdi = i[0]; sck = 1'b1; tk(H); sck = 1'b0; tk(H);
    end
    hold_n = 1'b1; tk(H);
    xbyte(8'h4E, d); end_f(); wait_wc();
    rd(16'h0120, 2);
    chk("R9 byte before hold", rb[0], 8'h3D);
    chk("R9 clocks in hold ignored", rb[1], 8'h4E);
    begin_f(); xbyte(8'h03, d); xbyte(8'h01, d); xbyte(8'h20, d);
    tk(H);
    chk("R9 driving before hold", sdo_oe, 1'b1);
    hold_n = 1'b0; tk(H);
    chk("R9 output released in hold", sdo_oe, 1'b0);
    sck = 1'b1; tk(H); sck = 1'b0; tk(H);
    hold_n = 1'b1; tk(H);
    xbyte(8'h00, d); end_f();
    chk("R9 read resumes after hold", d, 8'h3D);
  endtask

  task automatic t_wrsr();
    logic [7:0] s, d;
    int w0;
    cmd1(8'h06);
    w0 = we_cnt;
    begin_f(); xbyte(8'h01, d); xbyte(8'h8C, d); end_f();
    chk("R11 one request", we_cnt - w0, 1);
    chk("R11 request data", we_last, 8'h8C);
    rdsr(s);
    chk("R8 latch clear after status write", s, {stat_hi, 2'b00});
    cmd1(8'h06);
    w0 = we_cnt;
    begin_f(); xbyte(8'h01, d); xbyte(8'h8C, d); xbyte(8'h11, d); end_f();
    chk("R11 two data bytes no request", we_cnt - w0, 0);
  endtask

  initial begin
    t_reset();
    t_wel();
    t_basic();
    t_mode3();
    t_partial();
    t_no_wel();
    t_wrap();
    t_rdwrap();
    t_busy();
    t_hold();
    t_wrsr();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL timeout all-requirements act=running exp=done");
    summary();
  end
endmodule